// File: doc/BRIEF.md
# Accumulator ALU with Carry, Half-Carry and Overflow Flags

This block is the execute stage of a small 8-bit accumulator machine. It holds the accumulator (A), the auxiliary operand register (B) and three status flags: carry (C), auxiliary carry (AC) and overflow (OV). Each cycle with `op_valid_i` high applies one operation, picked by `op_i`, to A, B and the operand byte `opnd_i`. The new A, B and flag values appear on the outputs after the next rising clock edge.

The operations are:

- add, add with carry and subtract with borrow;
- increment and decrement of A;
- an 8x8 multiply into B:A and an 8/8 divide into quotient and remainder;
- BCD decimal adjust;
- bitwise AND, OR and XOR with the operand, and complement and clear of A;
- rotates left and right, with or without carry, and nibble swap.

Load operations for A and B and set/clear operations for C let an operand fetch stage outside the block prepare the state.

Each operation has its own flag effects. Subtraction always takes the borrow. Increment, decrement and the bitwise operations leave the flags alone. Divide reports a zero divisor in OV. Decimal adjust corrects each nibble by 6.

Top module: `acc_alu`

## Requirements
- R1: ADD (op 3) writes A+opnd to A. ADDC (op 4) writes A+opnd+C to A. Both set C on a carry out of bit 7 and AC on a carry out of bit 3. Both set OV when exactly one of the carries out of bit 6 and bit 7 occurs. Example: 0x3F+0xD3 gives 0x12 with C=1, AC=1, OV=0.
- R2: SUBB (op 5) writes A-opnd-C to A. It sets C on a borrow out of bit 7 and AC on a borrow out of bit 3. It sets OV on signed overflow of the subtraction.
- R3: INC (op 6) and DEC (op 7) add or subtract one from A, wrapping modulo 256. C, AC and OV are unchanged.
- R4: MUL (op 8) writes the low byte of A*B to A and the high byte to B. It clears C and sets OV when the product exceeds 0xFF. 0xFF*0xFF gives B=0xFE, A=0x01.
- R5: DIV (op 9) writes the quotient A/B to A and the remainder to B, and always clears C. With B=0 it sets OV; A and B are then unspecified. Otherwise it clears OV.
- R6: DA (op 10) adds 6 to A when its low nibble exceeds 9 or AC=1. It then adds 0x60 when the high nibble exceeds 9 or C is set, and sets C when it does. Otherwise C is kept. Example: 0x23+0x29 followed by DA gives 0x52.
- R7: ANL (op 11), ORL (op 12) and XRL (op 13) combine A with opnd. CPL (op 14) inverts A and CLR (op 15) zeroes A. None of them changes C, AC or OV.
- R8: RL (op 16) and RR (op 18) rotate A by one bit; 0xF0 RL gives 0xE1. RLC (op 17) and RRC (op 19) rotate A through C; 0xBD RRC with C=0 gives 0x5E with C=1. SWAP (op 20) exchanges nibbles; 0x72 gives 0x27. AC and OV are unchanged.
- R9: LDA (op 1) and LDB (op 2) load opnd into A or B and leave the flags unchanged. SETC (op 21) sets C and CLRC (op 22) clears it. With `op_valid_i` low, or with NOP (op 0), all state holds.
- R10: After an asynchronous reset A, B, C, AC and OV are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Apply op_i this cycle |
| op_i | input | 5 | Operation code |
| opnd_i | input | 8 | Operand byte |
| a_o | output | 8 | Accumulator |
| b_o | output | 8 | B register |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |
| ov_o | output | 1 | Overflow flag |

## Verification
The assertions take `op_i` and `opnd_i` to be stable and known whenever `op_valid_i` is high. They do not constrain A or B after a divide by zero, because those values are unspecified. The bench drives every input well away from the clock edge and gives at most one operation per cycle. It only issues the defined codes 0 to 22, and it checks A and B after a zero-divisor divide only for the flags.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,  OP_LDA  = 5'd1,  OP_LDB  = 5'd2,  OP_ADD  = 5'd3,
    OP_ADDC = 5'd4,  OP_SUBB = 5'd5,  OP_INC  = 5'd6,  OP_DEC  = 5'd7,
    OP_MUL  = 5'd8,  OP_DIV  = 5'd9,  OP_DA   = 5'd10, OP_ANL  = 5'd11,
    OP_ORL  = 5'd12, OP_XRL  = 5'd13, OP_CPL  = 5'd14, OP_CLR  = 5'd15,
    OP_RL   = 5'd16, OP_RLC  = 5'd17, OP_RR   = 5'd18, OP_RRC  = 5'd19,
    OP_SWAP = 5'd20, OP_SETC = 5'd21, OP_CLRC = 5'd22
  } op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flags_t;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  flags_t            flg_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);

  localparam int unsigned NIB_W = DATA_W / 2;
  localparam int unsigned HI_W  = DATA_W - NIB_W;

  logic              cin;
  logic [DATA_W:0]   sum, diff;
  logic [NIB_W:0]    sum_lo, diff_lo;
  logic [DATA_W-1:0] sum_b6;
  logic [DATA_W:0]   da_s1, da_s2;
  logic              da_lo_fix, da_hi_fix;

  always_comb begin
    cin     = (op_i == OP_ADDC || op_i == OP_SUBB) ? flg_i.cy : 1'b0;
    sum     = {1'b0, a_i} + {1'b0, opnd_i} + {{DATA_W{1'b0}}, cin};
    diff    = {1'b0, a_i} - {1'b0, opnd_i} - {{DATA_W{1'b0}}, cin};
    sum_lo  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, opnd_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    diff_lo = {1'b0, a_i[NIB_W-1:0]} - {1'b0, opnd_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
    // carry out of the bit below the msb
    sum_b6  = {1'b0, a_i[DATA_W-2:0]} + {1'b0, opnd_i[DATA_W-2:0]} + {{(DATA_W-1){1'b0}}, cin};

    // decimal adjust: low nibble first, high nibble sees its result
    da_lo_fix = (a_i[NIB_W-1:0] > NIB_W'(9)) || flg_i.ac;
    da_s1     = {1'b0, a_i} + (da_lo_fix ? (DATA_W+1)'(6) : '0);
    da_hi_fix = (da_s1[DATA_W-1:NIB_W] > HI_W'(9)) || flg_i.cy || da_s1[DATA_W];
    da_s2     = {1'b0, da_s1[DATA_W-1:0]} + (da_hi_fix ? ((DATA_W+1)'(6) << NIB_W) : '0);

    res_o = a_i;
    flg_o = flg_i;
    unique case (op_i)
      OP_ADD, OP_ADDC: begin
        res_o    = sum[DATA_W-1:0];
        flg_o.cy = sum[DATA_W];
        flg_o.ac = sum_lo[NIB_W];
        flg_o.ov = sum[DATA_W] ^ sum_b6[DATA_W-1];
      end
      OP_SUBB: begin
        res_o    = diff[DATA_W-1:0];
        flg_o.cy = diff[DATA_W];
        flg_o.ac = diff_lo[NIB_W];
        flg_o.ov = (a_i[DATA_W-1] != opnd_i[DATA_W-1]) &&
                   (diff[DATA_W-1] != a_i[DATA_W-1]);
      end
      OP_INC: res_o = a_i + DATA_W'(1);
      OP_DEC: res_o = a_i - DATA_W'(1);
      OP_DA: begin
        res_o    = da_s2[DATA_W-1:0];
        flg_o.cy = da_hi_fix;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              is_div_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  flags_t            flg_i,
  output logic [DATA_W-1:0] res_a_o,
  output logic [DATA_W-1:0] res_b_o,
  output flags_t            flg_o
);

  logic [2*DATA_W-1:0] prod;
  logic [DATA_W:0]     rem;
  logic [DATA_W-1:0]   quo;
  logic                div_zero;

  assign prod     = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
  assign div_zero = (b_i == '0);

  // restoring division, one quotient bit per unrolled step
  always_comb begin
    rem = '0;
    quo = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      rem = {rem[DATA_W-1:0], a_i[i]};
      if (rem >= {1'b0, b_i}) begin
        rem    = rem - {1'b0, b_i};
        quo[i] = 1'b1;
      end
    end
  end

  always_comb begin
    flg_o    = flg_i;
    flg_o.cy = 1'b0;
    if (is_div_i) begin
      flg_o.ov = div_zero;
      res_a_o  = div_zero ? a_i : quo;
      res_b_o  = div_zero ? b_i : rem[DATA_W-1:0];
    end else begin
      flg_o.ov = (prod[2*DATA_W-1:DATA_W] != '0);
      res_a_o  = prod[DATA_W-1:0];
      res_b_o  = prod[2*DATA_W-1:DATA_W];
    end
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  flags_t            flg_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);

  localparam int unsigned NIB_W = DATA_W / 2;

  always_comb begin
    res_o = a_i;
    flg_o = flg_i;
    unique case (op_i)
      OP_ANL:  res_o = a_i & opnd_i;
      OP_ORL:  res_o = a_i | opnd_i;
      OP_XRL:  res_o = a_i ^ opnd_i;
      OP_CPL:  res_o = ~a_i;
      OP_CLR:  res_o = '0;
      OP_RL:   res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
      OP_RR:   res_o = {a_i[0], a_i[DATA_W-1:1]};
      OP_RLC: begin
        res_o    = {a_i[DATA_W-2:0], flg_i.cy};
        flg_o.cy = a_i[DATA_W-1];
      end
      OP_RRC: begin
        res_o    = {flg_i.cy, a_i[DATA_W-1:1]};
        flg_o.cy = a_i[0];
      end
      OP_SWAP: res_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OP_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);

  op_e               op;
  logic [DATA_W-1:0] a_q, b_q, a_d, b_d;
  flags_t            flg_q, flg_d;

  logic [DATA_W-1:0] ar_res, lg_res, md_a, md_b;
  flags_t            ar_flg, lg_flg, md_flg;

  assign op = op_e'(op_i);

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i(op), .a_i(a_q), .opnd_i(opnd_i), .flg_i(flg_q),
    .res_o(ar_res), .flg_o(ar_flg)
  );

  acc_alu_muldiv #(.DATA_W(DATA_W)) u_muldiv (
    .is_div_i(op == OP_DIV), .a_i(a_q), .b_i(b_q), .flg_i(flg_q),
    .res_a_o(md_a), .res_b_o(md_b), .flg_o(md_flg)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op), .a_i(a_q), .opnd_i(opnd_i), .flg_i(flg_q),
    .res_o(lg_res), .flg_o(lg_flg)
  );

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    flg_d = flg_q;
    if (op_valid_i) begin
      unique case (op)
        OP_LDA:  a_d = opnd_i;
        OP_LDB:  b_d = opnd_i;
        OP_SETC: flg_d.cy = 1'b1;
        OP_CLRC: flg_d.cy = 1'b0;
        OP_ADD, OP_ADDC, OP_SUBB, OP_INC, OP_DEC, OP_DA: begin
          a_d   = ar_res;
          flg_d = ar_flg;
        end
        OP_MUL, OP_DIV: begin
          a_d   = md_a;
          b_d   = md_b;
          flg_d = md_flg;
        end
        OP_ANL, OP_ORL, OP_XRL, OP_CPL, OP_CLR,
        OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SWAP: begin
          a_d   = lg_res;
          flg_d = lg_flg;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      flg_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      flg_q <= flg_d;
    end
  end

  assign a_o  = a_q;
  assign b_o  = b_q;
  assign cy_o = flg_q.cy;
  assign ac_o = flg_q.ac;
  assign ov_o = flg_q.ov;

  logic is_logic_op;
  assign is_logic_op = op inside {OP_ANL, OP_ORL, OP_XRL, OP_CPL, OP_CLR};

  AST_INCDEC_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op == OP_INC || op == OP_DEC) |=> $stable({cy_o, ac_o, ov_o})); // R3
  AST_MUL_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op == OP_MUL |=>
      {b_o, a_o} == ({{DATA_W{1'b0}}, $past(a_o)} * {{DATA_W{1'b0}}, $past(b_o)})); // R4
  AST_DIV_CLEARS_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op == OP_DIV |=> !cy_o); // R5
  AST_DIV_ZERO_OV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op == OP_DIV && b_o == '0 |=> ov_o); // R5
  AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && is_logic_op |=> $stable({cy_o, ac_o, ov_o})); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable({a_o, b_o, cy_o, ac_o, ov_o})); // R9

endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;

  localparam logic [4:0] NOP = 0, LDA = 1, LDB = 2, ADD = 3, ADDC = 4, SUBB = 5,
    INC = 6, DEC = 7, MUL = 8, DIV = 9, DA = 10, ANL = 11, ORL = 12, XRL = 13,
    CPL = 14, CLR = 15, RL = 16, RLC = 17, RR = 18, RRC = 19, SWAP = 20,
    SETC = 21, CLRC = 22;

  typedef struct packed {
    logic [3:0] rq;
    logic [7:0] a, b;
    logic       c;
    logic [4:0] op;
    logic [7:0] opnd, ea, eb;
    logic       ec, eac, eov, chk_ab;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 8'h3F, 8'h00, 1'b0, ADD,  8'hD3, 8'h12, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R1
    '{4'd1, 8'h3F, 8'h00, 1'b1, ADDC, 8'hD3, 8'h13, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R1
    '{4'd1, 8'h7F, 8'h00, 1'b0, ADD,  8'h73, 8'hF2, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1}, // R1
    '{4'd1, 8'h8F, 8'h00, 1'b0, ADD,  8'hD3, 8'h62, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1}, // R1
    '{4'd2, 8'h50, 8'h00, 1'b0, SUBB, 8'h4F, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}, // R2
    '{4'd2, 8'h50, 8'h00, 1'b1, SUBB, 8'h4F, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}, // R2
    '{4'd2, 8'h20, 8'h00, 1'b0, SUBB, 8'h30, 8'hF0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R2
    '{4'd2, 8'h80, 8'h00, 1'b0, SUBB, 8'h01, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1}, // R2
    '{4'd3, 8'hFF, 8'h00, 1'b1, INC,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R3
    '{4'd3, 8'h00, 8'h00, 1'b0, DEC,  8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
    '{4'd4, 8'hFF, 8'hFF, 1'b1, MUL,  8'h00, 8'h01, 8'hFE, 1'b0, 1'b0, 1'b1, 1'b1}, // R4
    '{4'd4, 8'h10, 8'h0F, 1'b1, MUL,  8'h00, 8'hF0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
    '{4'd5, 8'hFB, 8'h10, 1'b1, DIV,  8'h00, 8'h0F, 8'h0B, 1'b0, 1'b0, 1'b0, 1'b1}, // R5
    '{4'd5, 8'h05, 8'h00, 1'b1, DIV,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}, // R5
    '{4'd7, 8'hAC, 8'h00, 1'b1, ANL,  8'h0F, 8'h0C, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd7, 8'hAC, 8'h00, 1'b0, ORL,  8'h0F, 8'hAF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd7, 8'hAC, 8'h00, 1'b0, XRL,  8'h0F, 8'hA3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd7, 8'hAC, 8'h00, 1'b1, CPL,  8'h00, 8'h53, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd7, 8'hAC, 8'h00, 1'b0, CLR,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd8, 8'hF0, 8'h00, 1'b0, RL,   8'h00, 8'hE1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
    '{4'd8, 8'h01, 8'h00, 1'b1, RR,   8'h00, 8'h80, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R8
    '{4'd8, 8'h80, 8'h00, 1'b0, RLC,  8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R8
    '{4'd8, 8'hBD, 8'h00, 1'b0, RRC,  8'h00, 8'h5E, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R8
    '{4'd8, 8'h72, 8'h00, 1'b0, SWAP, 8'h00, 8'h27, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
    '{4'd9, 8'h11, 8'h00, 1'b1, LDB,  8'h5A, 8'h11, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b1}  // R9
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] opnd = '0;
  logic [7:0] a, b;
  logic       cy, ac, ov;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .op_i(op), .opnd_i(opnd),
    .a_o(a), .b_o(b), .cy_o(cy), .ac_o(ac), .ov_o(ov)
  );

  task automatic issue(input logic [4:0] o, input logic [7:0] d);
    @(posedge clk); #1;
    valid = 1'b1; op = o; opnd = d;
    @(posedge clk); #1;
    valid = 1'b0; op = NOP; opnd = '0;
  endtask

  task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", rq, what, act, exp);
    end
  endtask

  task automatic chk_state(input string rq, input logic [7:0] ea, input logic [7:0] eb,
                           input logic ec, input logic eac, input logic eov, input bit chk_ab);
    if (chk_ab) begin
      chk(rq, "A", a, ea);
      chk(rq, "B", b, eb);
    end
    chk(rq, "C", {7'd0, cy}, {7'd0, ec});
    chk(rq, "AC", {7'd0, ac}, {7'd0, eac});
    chk(rq, "OV", {7'd0, ov}, {7'd0, eov});
  endtask

  // zero all flags through the normal interface
  task automatic clear_flags();
    issue(LDA, 8'h00);
    issue(ADD, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_state("R10", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1); // R10 reset state
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].rq);
      clear_flags();
      if (VECS[i].c) issue(SETC, 8'h00);
      issue(LDA, VECS[i].a);
      issue(LDB, VECS[i].b);
      issue(VECS[i].op, VECS[i].opnd);
      chk_state(rq, VECS[i].ea, VECS[i].eb, VECS[i].ec, VECS[i].eac, VECS[i].eov, VECS[i].chk_ab);
    end

    // R6 decimal adjust after BCD adds
    clear_flags();
    issue(LDA, 8'h23); issue(ADD, 8'h29); issue(DA, 8'h00);
    chk_state("R6", 8'h52, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6", "A", a, 8'h52);
    clear_flags();
    issue(LDA, 8'h99); issue(ADD, 8'h01); issue(DA, 8'h00);
    chk("R6", "A", a, 8'h00);
    chk("R6", "C", {7'd0, cy}, 8'h01);
    clear_flags();
    issue(LDA, 8'h09); issue(ADD, 8'h09); issue(DA, 8'h00);
    chk("R6", "A", a, 8'h18);
    chk("R6", "C", {7'd0, cy}, 8'h00);

    // R3 and R7 with all flags set: 0x88+0x88 gives C=AC=OV=1
    clear_flags();
    issue(LDA, 8'h88); issue(ADD, 8'h88);
    chk_state("R1", 8'h10, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0);
    issue(INC, 8'h00);
    chk_state("R3", 8'h11, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1);
    issue(XRL, 8'hFF);
    chk_state("R7", 8'hEE, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1);
    issue(SWAP, 8'h00);
    chk_state("R8", 8'hEE, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1);
    issue(CLRC, 8'h00);
    chk_state("R9", 8'hEE, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b1);

    // R9 idle cycle with op inputs busy but valid low
    @(posedge clk); #1;
    op = CLR; opnd = 8'h00;
    @(posedge clk); #1;
    op = NOP;
    chk_state("R9", 8'hEE, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b1);
    issue(NOP, 8'h77);
    chk_state("R9", 8'hEE, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b1);

    // R10 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk_state("R10", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1 rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule